// File: doc/BRIEF.md
# I2C SCL Period Generator

This block produces the SCL clock of an I2C master. Four count registers (high and low count for standard speed, high and low count for fast speed) set the phase lengths, and a two-bit speed field selects which pair is live. A bit engine issues one operation at a time: START, BIT, or STOP. A START issued while the block holds SCL low becomes a repeated START. The generator drives SCL low through an open-drain enable. It reads the line back through `scl_in`, which it takes to be already synchronized to `clk`.

The low phase is counted from the clock edge at which the block pulls SCL low, so the line's fall time is part of the programmed low time. The high phase is counted only once the line is seen high, so a target that holds SCL low stretches the clock. The bit engine gets single-cycle strobes:
- one when SDA must fall for a START;
- one in the middle of each high phase, for sampling;
- one in the middle of each low phase, for changing data;
- a completion strobe for each operation.

Top module: `scl_period_gen`

## Requirements
- R1: After reset, SCL is released, no strobe is active, and `cmd_ready` is low while `enable` is low and high once it is set. The count registers hold their reset parameter values (standard high, standard low, fast high, fast low).
- R2: `speed_mode` 2'b10 selects the fast pair. Any other value (2'b01 normally) selects the standard pair.
- R3: Without stretching, each BIT high phase releases SCL for high count + 8 cycles.
- R4: Each low phase holds SCL driven low for exactly low count + 1 cycles when the next operation is already waiting. `cmd_ready` rises in the last of those cycles.
- R5: High counting starts at the first clock edge that sees `scl_in` high. SCL is pulled low again high count + 7 cycles after that edge. While a target holds the line, SCL stays released and no sample strobe fires.
- R6: A START accepted with SCL released keeps SCL released for high count + 3 cycles after the accepting edge, then pulls it low. `tick_start` is high in the first of those cycles.
- R7: A START accepted while SCL is held low releases SCL for (high count + 8) + (high count + 3) cycles. `tick_start` fires high count + 8 cycles into that release.
- R8: STOP releases SCL, raises `op_done` in cycle high count + 7 of the release, and leaves SCL released.
- R9: `tick_sample` fires 1 + ((high count + 6) >> 1) cycles into a high phase. `tick_change` fires (low count >> 1) cycles into a low phase. No two strobes are ever active together.
- R10: Count registers are written through `cfg_addr` (0 standard high, 1 standard low, 2 fast high, 3 fast low) only while `enable` is low. A write while enabled has no effect.
- R11: Clearing `enable` releases SCL on the next cycle and abandons the operation in progress.
- R12: Operation code 2'b11 is never accepted and causes no bus activity. The valid codes are 2'b00 START, 2'b01 BIT and 2'b10 STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low releases SCL and unlocks the count registers |
| speed_mode | input | 2 | 2'b10 fast pair, otherwise standard pair |
| cfg_we | input | 1 | Count register write strobe |
| cfg_addr | input | 2 | Count register select |
| cfg_wdata | input | CNT_W | Count register write value |
| cmd_valid | input | 1 | Operation request |
| cmd_op | input | 2 | Operation code |
| cmd_ready | output | 1 | Operation can be accepted this cycle |
| scl_in | input | 1 | Synchronized SCL line level |
| scl_drive_low | output | 1 | Pull SCL low when high |
| tick_start | output | 1 | SDA must fall now (START) |
| tick_sample | output | 1 | Middle of SCL high |
| tick_change | output | 1 | Middle of SCL low |
| op_done | output | 1 | Operation completed |

## Verification
The bench builds the block with `CNT_W` = 8 and small, mutually distinct reset values. Reading back phase lengths therefore shows which of the four registers came out of reset, and runs with both counts at 0 and at 255 stay short. With the narrow counter, the widest high phase (255 + 8 cycles) still exercises the counter's extra headroom bits. The two-cycle-long reset values also keep the standard and fast pairs apart when the speed field falls back to standard.

// File: rtl/scl_period_gen.sv
module scl_period_gen #(
  parameter int CNT_W     = 16,
  parameter int RST_SS_HI = 392,
  parameter int RST_SS_LO = 499,
  parameter int RST_FS_HI = 52,
  parameter int RST_FS_LO = 159
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       speed_mode,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  output logic             cmd_ready,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             tick_start,
  output logic             tick_sample,
  output logic             tick_change,
  output logic             op_done
);

  localparam int CW       = CNT_W + 4;
  localparam int HI_OVH   = 8;
  localparam int HOLD_OVH = 3;
  localparam int LO_OVH   = 1;

  localparam logic [1:0] OP_START = 2'b00;
  localparam logic [1:0] OP_BIT   = 2'b01;
  localparam logic [1:0] OP_STOP  = 2'b10;
  localparam logic [1:0] OP_NONE  = 2'b11;

  typedef enum logic [2:0] {S_REL, S_HOLD, S_WAITHI, S_HIGH, S_LOWW} state_t;

  state_t           st;
  logic [CW-1:0]    cnt;
  logic [1:0]       op;
  logic [CNT_W-1:0] ss_hi, ss_lo, fs_hi, fs_lo;
  logic [CNT_W-1:0] hi_sel, lo_sel;
  logic [CW-1:0]    hi_end, hold_end, lo_end;
  logic             fast, lo_met, accept, hi_last;

  assign fast     = (speed_mode == 2'b10);
  assign hi_sel   = fast ? fs_hi : ss_hi;
  assign lo_sel   = fast ? fs_lo : ss_lo;
  assign hi_end   = CW'(hi_sel) + CW'(HI_OVH - 2);
  assign hold_end = CW'(hi_sel) + CW'(HOLD_OVH - 1);
  assign lo_end   = CW'(lo_sel) + CW'(LO_OVH - 1);

  assign lo_met    = (st == S_LOWW) && (cnt >= lo_end);
  assign cmd_ready = enable && ((st == S_REL) || lo_met);
  assign accept    = cmd_valid && cmd_ready && (cmd_op != OP_NONE);
  assign hi_last   = (st == S_HIGH) && (cnt == hi_end);

  assign tick_start  = (st == S_HOLD) && (cnt == '0);
  assign tick_sample = (st == S_HIGH) && (cnt == (hi_end >> 1));
  assign tick_change = (st == S_LOWW) && (cnt == (lo_end >> 1));
  assign op_done     = ((st == S_LOWW) && (cnt == lo_end)) || (hi_last && (op == OP_STOP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_hi <= CNT_W'(RST_SS_HI);
      ss_lo <= CNT_W'(RST_SS_LO);
      fs_hi <= CNT_W'(RST_FS_HI);
      fs_lo <= CNT_W'(RST_FS_LO);
    end else if (cfg_we && !enable) begin
      case (cfg_addr)
        2'd0:    ss_hi <= cfg_wdata;
        2'd1:    ss_lo <= cfg_wdata;
        2'd2:    fs_hi <= cfg_wdata;
        default: fs_lo <= cfg_wdata;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= S_REL;
      cnt           <= '0;
      op            <= OP_BIT;
      scl_drive_low <= 1'b0;
    end else if (!enable) begin
      st            <= S_REL;
      cnt           <= '0;
      scl_drive_low <= 1'b0;
    end else begin
      case (st)
        S_REL: begin
          if (accept) begin
            op  <= cmd_op;
            cnt <= '0;
            st  <= (cmd_op == OP_START) ? S_HOLD : S_WAITHI;
          end
        end
        S_LOWW: begin
          if (cnt <= lo_end) cnt <= cnt + CW'(1);
          if (accept) begin
            op            <= cmd_op;
            cnt           <= '0;
            scl_drive_low <= 1'b0;
            st            <= S_WAITHI;
          end
        end
        S_WAITHI: begin
          if (scl_in) begin
            cnt <= '0;
            st  <= S_HIGH;
          end
        end
        S_HIGH: begin
          if (hi_last) begin
            cnt <= '0;
            case (op)
              OP_START: st <= S_HOLD;
              OP_STOP:  st <= S_REL;
              default: begin
                scl_drive_low <= 1'b1;
                st            <= S_LOWW;
              end
            endcase
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_HOLD: begin
          if (cnt == hold_end) begin
            cnt           <= '0;
            scl_drive_low <= 1'b1;
            st            <= S_LOWW;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: st <= S_REL;
      endcase
    end
  end

endmodule

// File: rtl/scl_period_gen_chk.sv
module scl_period_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             scl_in,
  input logic             scl_drive_low,
  input logic             tick_start,
  input logic             tick_sample,
  input logic             tick_change,
  input logic [CNT_W-1:0] ss_hi,
  input logic [CNT_W-1:0] ss_lo,
  input logic [CNT_W-1:0] fs_hi,
  input logic [CNT_W-1:0] fs_lo,
  input logic [CNT_W-1:0] lo_sel
);

  logic [31:0] lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             lo_run <= '0;
    else if (scl_drive_low) lo_run <= lo_run + 32'd1;
    else                    lo_run <= '0;
  end

  AST_TICK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tick_start, tick_sample, tick_change})); // R9

  AST_CHANGE_WHILE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    tick_change |-> scl_drive_low); // R9

  AST_SAMPLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tick_sample |-> (scl_in && !scl_drive_low)); // R5

  AST_START_LINE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    tick_start |-> !scl_drive_low); // R6

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> $stable({ss_hi, ss_lo, fs_hi, fs_lo})); // R10

  AST_DISABLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !scl_drive_low); // R11

  AST_LOW_MINIMUM: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_drive_low) && $past(enable)) |-> (lo_run >= 32'(lo_sel) + 32'd1)); // R4

endmodule

bind scl_period_gen scl_period_gen_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .scl_in(scl_in),
  .scl_drive_low(scl_drive_low), .tick_start(tick_start),
  .tick_sample(tick_sample), .tick_change(tick_change),
  .ss_hi(ss_hi), .ss_lo(ss_lo), .fs_hi(fs_hi), .fs_lo(fs_lo), .lo_sel(lo_sel)
);

// File: tb/scl_period_gen_tb_top.sv
`timescale 1ns/1ps
module scl_period_gen_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [1:0] speed_mode = 2'b01;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [W-1:0] cfg_wdata = '0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b01;
  logic cmd_ready, scl_in, scl_drive_low;
  logic tick_start, tick_sample, tick_change, op_done;
  logic stretch = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  assign scl_in = !(scl_drive_low || stretch);

  scl_period_gen #(.CNT_W(W), .RST_SS_HI(6), .RST_SS_LO(3), .RST_FS_HI(1), .RST_FS_LO(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .speed_mode(speed_mode),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ready(cmd_ready),
    .scl_in(scl_in), .scl_drive_low(scl_drive_low), .tick_start(tick_start),
    .tick_sample(tick_sample), .tick_change(tick_change), .op_done(op_done));

  int low_runs[16], rel_runs[16], chg_off[16], samp_off[16], st_off[16], dn_off[16], dn_lvl[16];
  int n_low, n_rel, n_chg, n_samp, n_st, n_dn;
  int rc = 0;
  logic prev_dl = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      rc = 0; prev_dl = 1'b0;
    end else begin
      if (scl_drive_low != prev_dl) begin
        if (prev_dl) begin if (n_low < 16) low_runs[n_low] = rc; n_low++; end
        else begin if (n_rel < 16) rel_runs[n_rel] = rc; n_rel++; end
        rc = 0; prev_dl = scl_drive_low;
      end
      if (tick_change && n_chg < 16) begin chg_off[n_chg] = rc; n_chg++; end
      if (tick_sample && n_samp < 16) begin samp_off[n_samp] = rc; n_samp++; end
      if (tick_start && n_st < 16) begin st_off[n_st] = rc; n_st++; end
      if (op_done && n_dn < 16) begin dn_off[n_dn] = rc; dn_lvl[n_dn] = int'(scl_drive_low); n_dn++; end
      rc++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    @(posedge clk);
    n_low = 0; n_rel = 0; n_chg = 0; n_samp = 0; n_st = 0; n_dn = 0;
    @(negedge clk);
  endtask

  task automatic send(input logic [1:0] op);
    cmd_op = op; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    int g = 0;
    while (!op_done && g < 2000) begin @(negedge clk); g++; end
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [1:0] a, input int v);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = W'(v);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // START, BIT, BIT, STOP back to back from a released bus
  task automatic run_seq(input int hi, input int lo, input string ctx);
    int so = 1 + ((hi + 6) >> 1);
    clear_log();
    send(2'b00); send(2'b01); send(2'b01); send(2'b10);
    wait_done();
    repeat (3) @(negedge clk);
    chk({"R4 low0 ", ctx}, low_runs[0], lo + 1);
    chk({"R4 low1 ", ctx}, low_runs[1], lo + 1);
    chk({"R4 low2 ", ctx}, low_runs[2], lo + 1);
    chk({"R3 high1 ", ctx}, rel_runs[1], hi + 8);
    chk({"R3 high2 ", ctx}, rel_runs[2], hi + 8);
    chk({"R9 change ", ctx}, chg_off[1], lo >> 1);
    chk({"R9 sample ", ctx}, samp_off[0], so);
    chk({"R9 sample ", ctx}, samp_off[1], so);
    chk({"R8 done offset ", ctx}, dn_off[3], hi + 7);
    chk({"R8 done level ", ctx}, dn_lvl[3], 0);
    chk({"R8 released ", ctx}, int'(scl_drive_low), 0);
  endtask

  task automatic test_reset();
    chk("R1 scl released", int'(scl_drive_low), 0);
    chk("R1 strobes idle", int'({tick_start, tick_sample, tick_change, op_done}), 0);
    chk("R1 ready while disabled", int'(cmd_ready), 0);
    enable = 1'b1;
    @(negedge clk);
    chk("R1 ready when enabled", int'(cmd_ready), 1);
    speed_mode = 2'b01;
    run_seq(6, 3, "R1 standard reset values");
    speed_mode = 2'b10;
    run_seq(1, 2, "R1 R2 fast reset values");
  endtask

  task automatic test_program();
    enable = 1'b0; @(negedge clk);
    cfg_write(2'd0, 5); cfg_write(2'd1, 4); cfg_write(2'd2, 2); cfg_write(2'd3, 7);
    enable = 1'b1; @(negedge clk);
    speed_mode = 2'b01; run_seq(5, 4, "R2 standard");
    speed_mode = 2'b10; run_seq(2, 7, "R2 fast");
    speed_mode = 2'b00; run_seq(5, 4, "R2 fallback");
    speed_mode = 2'b01;
  endtask

  task automatic test_start();
    int n = 0;
    send(2'b00);
    chk("R6 tick_start first cycle", int'(tick_start), 1);
    while (!scl_drive_low && n < 1000) begin n++; @(negedge clk); end
    chk("R6 start hold", n, 5 + 3);
    send(2'b10); wait_done();
  endtask

  task automatic test_restart();
    clear_log();
    send(2'b00); send(2'b01); send(2'b00); send(2'b10);
    wait_done();
    chk("R7 restart release length", rel_runs[2], 2 * 5 + 11);
    chk("R7 tick_start count", n_st, 2);
    chk("R7 tick_start offset", st_off[1], 5 + 8);
    chk("R7 low after restart", low_runs[2], 4 + 1);
  endtask

  task automatic test_stretch();
    int bad = 0;
    int n = 0;
    send(2'b00);
    while (!scl_drive_low) @(negedge clk);
    stretch = 1'b1;
    send(2'b01);
    repeat (10) begin
      @(negedge clk);
      if (scl_drive_low || tick_sample) bad++;
    end
    stretch = 1'b0;
    chk("R5 quiet while stretched", bad, 0);
    while (n < 2000) begin
      @(negedge clk);
      if (scl_drive_low) break;
      n++;
    end
    chk("R5 high after stretch", n, 5 + 7);
    send(2'b10); wait_done();
  endtask

  task automatic test_bad_op();
    int bad = 0;
    cmd_op = 2'b11; cmd_valid = 1'b1;
    repeat (6) begin
      @(negedge clk);
      if (scl_drive_low || op_done || tick_start || tick_sample) bad++;
    end
    cmd_valid = 1'b0;
    chk("R12 code 11 ignored", bad, 0);
    chk("R12 still ready", int'(cmd_ready), 1);
  endtask

  task automatic test_cfg_lock();
    cfg_write(2'd1, 9);
    run_seq(5, 4, "R10 write while enabled ignored");
    enable = 1'b0; @(negedge clk);
    cfg_write(2'd1, 9);
    enable = 1'b1; @(negedge clk);
    run_seq(5, 9, "R10 write while disabled");
  endtask

  task automatic test_disable();
    send(2'b00);
    while (!scl_drive_low) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk("R11 released next cycle", int'(scl_drive_low), 0);
    chk("R11 not ready", int'(cmd_ready), 0);
    repeat (3) @(negedge clk);
    chk("R11 stays released", int'(scl_drive_low), 0);
    enable = 1'b1;
    @(negedge clk);
    chk("R11 idle after re-enable", int'(cmd_ready), 1);
  endtask

  task automatic test_limits();
    enable = 1'b0; @(negedge clk);
    cfg_write(2'd0, 0); cfg_write(2'd1, 0);
    enable = 1'b1; @(negedge clk);
    run_seq(0, 0, "R3 R4 zero counts");
    enable = 1'b0; @(negedge clk);
    cfg_write(2'd0, 255); cfg_write(2'd1, 255);
    enable = 1'b1; @(negedge clk);
    run_seq(255, 255, "R3 R4 maximum counts");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_program();
    test_start();
    test_restart();
    test_stretch();
    test_bad_op();
    test_cfg_lock();
    test_disable();
    test_limits();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule